// File: doc/BRIEF.md
# Quadrature Phase Counter with Condition Mask

This block counts the phase relationship between two external square-wave inputs, A and B, into a 16-bit up/down register. Every edge on one input is qualified by the level of the other, which gives eight distinct count conditions. An eight-bit mask selects which conditions act. Four of the conditions always count up and the other four always count down. With the full mask the block behaves as a 4x quadrature decoder. With part of the mask cleared it counts at 2x or 1x resolution, or in one direction only.

A run input gates counting. The count register can be loaded at any time and is always readable. A compare value raises a match flag when a count step lands on it. A third external input, the capture pin, copies the count into a capture register on a selectable edge. Wrap-around in either direction raises an overflow or an underflow flag. A clear-mode selector can reset the counter on a compare match or on a capture. The flags are sticky and cleared by writing 1. A per-flag enable feeds a single interrupt line.

Top module: `qpc_counter`

## Requirements
- R1: A, B and the capture pin each pass through a two-flop synchroniser and an edge register. A phase change driven before clock edge k appears on `cnt_q` after edge k+2 and not before.
- R2: When mask bit n is set for n = 0..3, the counter increments by one. Bit 0 is A rising while B is low. Bit 1 is B rising while A is high. Bit 2 is A falling while B is high. Bit 3 is B falling while A is low.
- R3: When mask bit n is set for n = 4..7, the counter decrements by one. Bit 4 is A rising while B is high. Bit 5 is B falling while A is high. Bit 6 is A falling while B is low. Bit 7 is B rising while A is low.
- R4: A transition whose mask bit is 0 leaves the count unchanged.
- R5: If A and B both change in the same synchronised cycle, no count occurs.
- R6: While `run_en` is 0, phase transitions do not change the count. After `run_en` returns to 1, only transitions that occur after that point count.
- R7: A `cnt_wr` pulse loads `cnt_wdata` on the next edge. This works whether the block is running or stopped, and the load takes priority over any count or clear in that cycle.
- R8: Incrementing from 0xFFFF wraps to 0x0000 and sets flag bit 2 (overflow). Every flag stays set until a 1 is written to its bit of `flag_clr`.
- R9: Decrementing from 0x0000 wraps to 0xFFFF and sets flag bit 3 (underflow).
- R10: A count step whose new value equals `cmp_val` sets flag bit 1 (match). When `clr_sel` = 1, that step loads 0 instead of the new value.
- R11: A capture-pin edge copies the count into `cap_q` and sets flag bit 0. The edge is rising when `cap_fall_sel` = 0 and falling when it is 1; the opposite edge is ignored. When `clr_sel` = 2, the counter is also cleared to 0. Values 0 and 3 of `clr_sel` never clear.
- R12: `irq` is registered and equals the OR over i of (`flag_q[i]` AND `irq_en[i]`), one clock after the flags.
- R13: Synchronous reset clears the count, the capture register, all flags and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_a | input | 1 | Asynchronous phase input A |
| phase_b | input | 1 | Asynchronous phase input B |
| cap_in | input | 1 | Asynchronous capture pin |
| cap_fall_sel | input | 1 | Capture edge: 0 rising, 1 falling |
| run_en | input | 1 | Counting enabled while 1 |
| cond_mask | input | 8 | Count condition enables (R2, R3) |
| clr_sel | input | 2 | Clear mode: 0 none, 1 on match, 2 on capture |
| cnt_wr | input | 1 | Load strobe for the counter |
| cnt_wdata | input | 16 | Counter load value |
| cmp_val | input | 16 | Compare value |
| flag_clr | input | 4 | Write-1-to-clear strobes for the flags |
| irq_en | input | 4 | Per-flag interrupt enables |
| cnt_q | output | 16 | Current count |
| cap_q | output | 16 | Captured count |
| flag_q | output | 4 | Flags: 0 capture, 1 match, 2 overflow, 3 underflow |
| irq | output | 1 | Interrupt request |

## Verification
Several properties are checked by assertions on every cycle: a stopped counter holds its value, a load appears one cycle later, the decoder never asks for up and down together, and a clash of simultaneous edges never produces a step. They also check that each flag stays set until it is cleared, and that the value seen when a wrap, match-clear or capture-clear flag rises is the correct one. The exact condition-to-direction mapping under each of the 256 masks, the synchroniser latency, the capture edge selection and the interrupt gating can only be shown by the bench's scenarios. Those scenarios drive phase sequences and compare the count against values computed arithmetically from the mask.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  localparam int N_COND = 8;
  localparam int N_HALF = N_COND / 2;
  localparam int N_FLAG = 4;

  localparam int F_CAP = 0;
  localparam int F_MAT = 1;
  localparam int F_OVF = 2;
  localparam int F_UDF = 3;

  // condition indices, increment half first
  localparam int C_AR_BL = 0;
  localparam int C_BR_AH = 1;
  localparam int C_AF_BH = 2;
  localparam int C_BF_AL = 3;
  localparam int C_AR_BH = 4;
  localparam int C_BF_AH = 5;
  localparam int C_AF_BL = 6;
  localparam int C_BR_AL = 7;

  typedef enum logic [1:0] {
    CLR_NONE       = 2'd0,
    CLR_ON_MATCH   = 2'd1,
    CLR_ON_CAPTURE = 2'd2,
    CLR_RSVD       = 2'd3
  } clr_mode_e;
endpackage

// File: rtl/qpc_edge_sync.sv
module qpc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic chg
);
  logic [STAGES:0] chain;
  logic            prev;

  assign chain[0] = din;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain[STAGES:1] <= '0;
      prev            <= 1'b0;
    end else begin
      chain[STAGES:1] <= chain[STAGES-1:0];
      prev            <= chain[STAGES];
    end
  end

  assign level = chain[STAGES];
  assign chg   = chain[STAGES] ^ prev;

  // R1: a reported change must come from the last synchroniser stage having moved
  p_chg_from_stage_r1: assert property (@(posedge clk) disable iff (rst)
    chg |-> (level != $past(level)));
endmodule

// File: rtl/qpc_cond_decode.sv
module qpc_cond_decode
  import qpc_pkg::*;
(
  input  logic              a_lvl,
  input  logic              a_chg,
  input  logic              b_lvl,
  input  logic              b_chg,
  input  logic [N_COND-1:0] mask,
  output logic              step_up,
  output logic              step_dn
);
  logic              a_rise, a_fall, b_rise, b_fall, clash;
  logic [N_COND-1:0] hit, act;

  assign a_rise = a_chg &  a_lvl;
  assign a_fall = a_chg & ~a_lvl;
  assign b_rise = b_chg &  b_lvl;
  assign b_fall = b_chg & ~b_lvl;
  assign clash  = a_chg & b_chg;

  always_comb begin
    hit          = '0;
    hit[C_AR_BL] = a_rise & ~b_lvl;
    hit[C_BR_AH] = b_rise &  a_lvl;
    hit[C_AF_BH] = a_fall &  b_lvl;
    hit[C_BF_AL] = b_fall & ~a_lvl;
    hit[C_AR_BH] = a_rise &  b_lvl;
    hit[C_BF_AH] = b_fall &  a_lvl;
    hit[C_AF_BL] = a_fall & ~b_lvl;
    hit[C_BR_AL] = b_rise & ~a_lvl;
  end

  assign act     = clash ? '0 : (hit & mask);
  assign step_up = |act[N_HALF-1:0];
  assign step_dn = |act[N_COND-1:N_HALF];

  always_comb begin
    // R2/R3: directions are exclusive
    p_up_dn_excl_r3: assert (!(step_up && step_dn));
    // R5: a clash of both inputs never yields a step
    p_clash_silent_r5: assert (!(a_chg && b_chg) || !(step_up || step_dn));
  end
endmodule

// File: rtl/qpc_flag_bank.sv
module qpc_flag_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] flag_o,
  output logic         irq_o
);
  logic [N-1:0] flag_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_r <= '0;
      irq_o  <= 1'b0;
    end else begin
      flag_r <= set_i | (flag_r & ~clr_i);
      irq_o  <= |(flag_r & en_i);
    end
  end

  assign flag_o = flag_r;

  generate
    for (genvar i = 0; i < N; i++) begin : g_chk
      // R8: sticky until written with 1
      p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (flag_r[i] && !clr_i[i]) |=> flag_r[i]);
    end
  endgenerate

  // R12: interrupt only follows an enabled flag
  p_irq_source_r12: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(|(flag_r & en_i)));
endmodule

// File: rtl/qpc_counter.sv
module qpc_counter
  import qpc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              phase_a,
  input  logic              phase_b,
  input  logic              cap_in,
  input  logic              cap_fall_sel,
  input  logic              run_en,
  input  logic [N_COND-1:0] cond_mask,
  input  logic [1:0]        clr_sel,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic [CNT_W-1:0]  cmp_val,
  input  logic [N_FLAG-1:0] flag_clr,
  input  logic [N_FLAG-1:0] irq_en,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [CNT_W-1:0]  cap_q,
  output logic [N_FLAG-1:0] flag_q,
  output logic              irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_MIN = '0;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic a_lvl, a_chg, b_lvl, b_chg, c_lvl, c_chg;
  logic step_up, step_dn;

  qpc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_a (
    .clk(clk), .rst(rst), .din(phase_a), .level(a_lvl), .chg(a_chg));
  qpc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_b (
    .clk(clk), .rst(rst), .din(phase_b), .level(b_lvl), .chg(b_chg));
  qpc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_c (
    .clk(clk), .rst(rst), .din(cap_in), .level(c_lvl), .chg(c_chg));

  qpc_cond_decode u_dec (
    .a_lvl(a_lvl), .a_chg(a_chg), .b_lvl(b_lvl), .b_chg(b_chg),
    .mask(cond_mask), .step_up(step_up), .step_dn(step_dn));

  clr_mode_e        mode;
  logic             cap_evt, cap_clr, do_step;
  logic             match_hit, ovf_hit, udf_hit;
  logic [CNT_W-1:0] cnt_r, cap_r, stepped;
  logic [N_FLAG-1:0] fset;

  assign mode    = clr_mode_e'(clr_sel);
  assign cap_evt = c_chg & (c_lvl ^ cap_fall_sel);
  assign cap_clr = cap_evt && (mode == CLR_ON_CAPTURE);
  assign do_step = run_en && (step_up || step_dn) && !cnt_wr && !cap_clr;
  assign stepped = step_up ? (cnt_r + CNT_ONE) : (cnt_r - CNT_ONE);

  assign match_hit = do_step && (stepped == cmp_val);
  assign ovf_hit   = do_step && step_up && (cnt_r == CNT_MAX);
  assign udf_hit   = do_step && step_dn && (cnt_r == CNT_MIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_r <= '0;
    end else if (cnt_wr) begin
      cnt_r <= cnt_wdata;
    end else if (cap_clr) begin
      cnt_r <= '0;
    end else if (do_step) begin
      cnt_r <= (match_hit && (mode == CLR_ON_MATCH)) ? '0 : stepped;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          cap_r <= '0;
    else if (cap_evt) cap_r <= cnt_r;
  end

  always_comb begin
    fset        = '0;
    fset[F_CAP] = cap_evt;
    fset[F_MAT] = match_hit;
    fset[F_OVF] = ovf_hit;
    fset[F_UDF] = udf_hit;
  end

  qpc_flag_bank #(.N(N_FLAG)) u_flags (
    .clk(clk), .rst(rst), .set_i(fset), .clr_i(flag_clr), .en_i(irq_en),
    .flag_o(flag_q), .irq_o(irq));

  assign cnt_q = cnt_r;
  assign cap_q = cap_r;

  // R6: stopped counter holds
  p_hold_stopped_r6: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !cnt_wr && !cap_clr) |=> $stable(cnt_q));
  // R7: load lands next cycle
  p_load_r7: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (cnt_q == $past(cnt_wdata)));
  // R8: overflow flag accompanies a zero count
  p_ovf_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q[F_OVF]) |-> (cnt_q == CNT_MIN));
  // R9: underflow flag accompanies an all-ones count
  p_udf_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    ($rose(flag_q[F_UDF]) && ($past(clr_sel) != 2'd1)) |-> (cnt_q == CNT_MAX));
  // R10: match-clear mode leaves zero
  p_match_clear_r10: assert property (@(posedge clk) disable iff (rst)
    ($rose(flag_q[F_MAT]) && ($past(clr_sel) == 2'd1)) |-> (cnt_q == CNT_MIN));
  // R11: capture-clear mode leaves zero unless a load won
  p_cap_clear_r11: assert property (@(posedge clk) disable iff (rst)
    ($rose(flag_q[F_CAP]) && ($past(clr_sel) == 2'd2) && !$past(cnt_wr))
      |-> (cnt_q == CNT_MIN));
endmodule

// File: tb/qpc_counter_tb.sv
`timescale 1ns/1ps
module qpc_counter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pa = 1'b0, pb = 1'b0, cap_in = 1'b0, cap_fall_sel = 1'b0;
  logic        run_en = 1'b0;
  logic [7:0]  mask_r = 8'h00;
  logic [1:0]  clr_sel = 2'd0;
  logic        cnt_wr = 1'b0;
  logic [15:0] cnt_wdata = 16'h0, cmp_val = 16'h7777;
  logic [3:0]  flag_clr = 4'h0, irq_en = 4'h0;
  logic [15:0] cnt_q, cap_q;
  logic [3:0]  flag_q;
  logic        irq;
  logic [15:0] exp_c;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  qpc_counter u_dut (
    .clk(clk), .rst(rst), .phase_a(pa), .phase_b(pb), .cap_in(cap_in),
    .cap_fall_sel(cap_fall_sel), .run_en(run_en), .cond_mask(mask_r),
    .clr_sel(clr_sel), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .cmp_val(cmp_val), .flag_clr(flag_clr), .irq_en(irq_en),
    .cnt_q(cnt_q), .cap_q(cap_q), .flag_q(flag_q), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic move(input logic na, input logic nb);
    @(negedge clk);
    pa = na;
    pb = nb;
    settle();
  endtask

  task automatic wr_cnt(input logic [15:0] v);
    @(negedge clk);
    cnt_wr = 1'b1;
    cnt_wdata = v;
    @(negedge clk);
    cnt_wr = 1'b0;
  endtask

  task automatic clr_flags(input logic [3:0] m);
    @(negedge clk);
    flag_clr = m;
    @(negedge clk);
    flag_clr = 4'h0;
    @(negedge clk);
  endtask

  task automatic sweep_step(input logic na, input logic nb, input int bi);
    string tag;
    move(na, nb);
    if (mask_r[bi]) begin
      exp_c = (bi < 4) ? exp_c + 16'd1 : exp_c - 16'd1;
      tag = (bi < 4) ? "R2 inc cond" : "R3 dec cond";
    end else begin
      tag = "R4 masked cond";
    end
    check(tag, {16'h0, cnt_q}, {16'h0, exp_c});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    check("R13 cnt", {16'h0, cnt_q}, 32'h0);
    check("R13 cap", {16'h0, cap_q}, 32'h0);
    check("R13 flags", {28'h0, flag_q}, 32'h0);
    check("R13 irq", {31'h0, irq}, 32'h0);

    // R1 latency
    run_en = 1'b1;
    mask_r = 8'hFF;
    @(negedge clk);
    pa = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 not yet", {16'h0, cnt_q}, 32'h0);
    @(negedge clk);
    check("R1 third edge", {16'h0, cnt_q}, 32'h1);
    move(1'b0, 1'b0);
    check("R1 back", {16'h0, cnt_q}, 32'h0);

    // R2 R3 R4 sweep over all masks
    for (int m = 0; m < 256; m++) begin
      mask_r = m[7:0];
      wr_cnt(16'h8000);
      exp_c = 16'h8000;
      sweep_step(1'b1, 1'b0, 0);
      sweep_step(1'b1, 1'b1, 1);
      sweep_step(1'b0, 1'b1, 2);
      sweep_step(1'b0, 1'b0, 3);
      sweep_step(1'b0, 1'b1, 7);
      sweep_step(1'b1, 1'b1, 4);
      sweep_step(1'b1, 1'b0, 5);
      sweep_step(1'b0, 1'b0, 6);
    end

    // R5 simultaneous change
    mask_r = 8'hFF;
    wr_cnt(16'h0100);
    move(1'b1, 1'b1);
    check("R5 clash up", {16'h0, cnt_q}, 32'h0100);
    move(1'b0, 1'b0);
    check("R5 clash down", {16'h0, cnt_q}, 32'h0100);
    move(1'b1, 1'b0);
    check("R5 single", {16'h0, cnt_q}, 32'h0101);
    move(1'b0, 1'b1);
    check("R5 cross clash", {16'h0, cnt_q}, 32'h0101);
    move(1'b1, 1'b0);
    check("R5 cross clash back", {16'h0, cnt_q}, 32'h0101);
    move(1'b0, 1'b0);
    check("R5 dec after", {16'h0, cnt_q}, 32'h0100);

    // R6 stop, R7 load while stopped
    run_en = 1'b0;
    wr_cnt(16'h0042);
    move(1'b1, 1'b0);
    move(1'b1, 1'b1);
    move(1'b0, 1'b1);
    move(1'b0, 1'b0);
    check("R6 stopped hold", {16'h0, cnt_q}, 32'h0042);
    run_en = 1'b1;
    settle();
    check("R6 no stale on restart", {16'h0, cnt_q}, 32'h0042);
    move(1'b1, 1'b0);
    check("R6 resumed", {16'h0, cnt_q}, 32'h0043);
    move(1'b0, 1'b0);
    wr_cnt(16'hBEEF);
    @(negedge clk);
    check("R7 load", {16'h0, cnt_q}, 32'hBEEF);

    // R8 overflow, R12 irq
    clr_flags(4'hF);
    mask_r = 8'h01;
    irq_en = 4'b0100;
    wr_cnt(16'hFFFF);
    move(1'b1, 1'b0);
    check("R8 wrap cnt", {16'h0, cnt_q}, 32'h0);
    check("R8 ovf flag", {28'h0, flag_q}, 32'h4);
    check("R12 irq on", {31'h0, irq}, 32'h1);
    move(1'b0, 1'b0);
    check("R8 sticky", {28'h0, flag_q}, 32'h4);
    clr_flags(4'b0100);
    check("R8 w1c", {28'h0, flag_q}, 32'h0);
    check("R12 irq off", {31'h0, irq}, 32'h0);

    // R9 underflow
    mask_r = 8'h10;
    irq_en = 4'b1000;
    wr_cnt(16'h0000);
    move(1'b0, 1'b1);
    check("R9 masked pre", {16'h0, cnt_q}, 32'h0);
    move(1'b1, 1'b1);
    check("R9 wrap cnt", {16'h0, cnt_q}, 32'hFFFF);
    check("R9 udf flag", {28'h0, flag_q}, 32'h8);
    check("R12 irq udf", {31'h0, irq}, 32'h1);
    move(1'b0, 1'b1);
    move(1'b0, 1'b0);
    clr_flags(4'hF);
    irq_en = 4'h0;

    // R10 compare
    mask_r = 8'h0F;
    cmp_val = 16'd5;
    wr_cnt(16'd3);
    move(1'b1, 1'b0);
    check("R10 no match", {28'h0, flag_q}, 32'h0);
    move(1'b1, 1'b1);
    check("R10 match val", {16'h0, cnt_q}, 32'd5);
    check("R10 match flag", {28'h0, flag_q}, 32'h2);
    clr_flags(4'b0010);
    clr_sel = 2'd1;
    wr_cnt(16'd3);
    move(1'b0, 1'b1);
    check("R10 step 4", {16'h0, cnt_q}, 32'd4);
    move(1'b0, 1'b0);
    check("R10 clear on match", {16'h0, cnt_q}, 32'd0);
    check("R10 flag clr mode", {28'h0, flag_q}, 32'h2);
    clr_sel = 2'd0;
    cmp_val = 16'h7777;
    clr_flags(4'hF);

    // R11 capture
    wr_cnt(16'h1234);
    @(negedge clk);
    cap_in = 1'b1;
    settle();
    check("R11 cap rise", {16'h0, cap_q}, 32'h1234);
    check("R11 cap flag", {28'h0, flag_q}, 32'h1);
    check("R11 no clear", {16'h0, cnt_q}, 32'h1234);
    clr_flags(4'hF);
    cap_fall_sel = 1'b1;
    settle();
    check("R11 sel change no evt", {28'h0, flag_q}, 32'h0);
    wr_cnt(16'h0ABC);
    @(negedge clk);
    cap_in = 1'b0;
    settle();
    check("R11 cap fall", {16'h0, cap_q}, 32'h0ABC);
    clr_flags(4'hF);
    wr_cnt(16'h0111);
    @(negedge clk);
    cap_in = 1'b1;
    settle();
    check("R11 opposite edge ignored", {16'h0, cap_q}, 32'h0ABC);
    check("R11 opposite no flag", {28'h0, flag_q}, 32'h0);
    clr_sel = 2'd2;
    wr_cnt(16'h0555);
    @(negedge clk);
    cap_in = 1'b0;
    settle();
    check("R11 cap before clear", {16'h0, cap_q}, 32'h0555);
    check("R11 clear on capture", {16'h0, cnt_q}, 32'h0);
    clr_sel = 2'd0;
    clr_flags(4'hF);

    // R12 enable gating
    mask_r = 8'h01;
    irq_en = 4'h0;
    wr_cnt(16'hFFFF);
    move(1'b1, 1'b0);
    check("R12 flag set", {28'h0, flag_q}, 32'h4);
    check("R12 gated off", {31'h0, irq}, 32'h0);
    @(negedge clk);
    irq_en = 4'b0100;
    @(negedge clk);
    check("R12 one cycle", {31'h0, irq}, 32'h1);
    move(1'b0, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule